// File: doc/BRIEF.md
# Rounding-Safe Accumulator Debug Sequencer

This block sits on the debug side of a processor. It takes one request to read or write a multiply-accumulate accumulator and turns it into four control-register transfers on a simple request/acknowledge bus. The accumulator datapath applies output rounding whenever the MAC status register selects a rounding mode. To stop that rounding from changing the bits that are transferred, the sequencer first reads the status register and keeps its value. It then writes zero to the status register, performs the accumulator access, and finally writes the kept value back.

A debug agent pulses `req_valid` together with the direction, a 2-bit accumulator index and, for writes, the data. The block raises `busy` and drives the four transfers one at a time. Each transfer waits for `cr_ack` before the next one is issued. A one-cycle `done` pulse marks the end of the sequence. After a read, the raw accumulator value stays on `rd_data`.

Top module: `acc_guard_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cr_req` are 0 and `rd_data` is all zeros.
- R2: A read request produces exactly four transfers, in this order: a read of the status code (default 0x804), a write of zero to the status code, a read of the accumulator code, and a write to the status code.
- R3: A write request produces the same four transfers, except that the third is a write of the request's data to the accumulator code (`cr_we`=1).
- R4: Accumulator index i is addressed with the code ACC_BASE+i (default 0x808+i), so index 3 uses code 0x80B.
- R5: The data of the final status write equals the data returned by the first status read of the same sequence.
- R6: While `cr_req` is high and `cr_ack` is low, `cr_req`, `cr_we`, `cr_addr` and `cr_wdata` hold their values. No transfer is issued before the previous one is acknowledged.
- R7: `done` is high for exactly one cycle: the cycle after the final status write is acknowledged. `busy` is high from the cycle after a request is accepted through the `done` cycle, and low after it.
- R8: After a read, `rd_data` holds the data returned with the accumulator read acknowledge. It stays unchanged until a later read's accumulator transfer completes, and write requests leave it unchanged.
- R9: A `req_valid` pulse while `busy` is high is ignored: it adds no transfer and does not change the index, direction or data of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write accumulator, 0 = read |
| req_idx | input | 2 | Accumulator index |
| req_wdata | input | DW | Data for a write request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rd_data | output | DW | Raw accumulator value from the last read |
| cr_req | output | 1 | Control-register transfer request |
| cr_we | output | 1 | 1 = write transfer, 0 = read transfer |
| cr_addr | output | CW | Control-register code |
| cr_wdata | output | DW | Write data of the transfer |
| cr_ack | input | 1 | Transfer acknowledge, valid while `cr_req` is high |
| cr_rdata | input | DW | Read data, valid with `cr_ack` |

## Verification
The bench builds the block with its default parameters: 32-bit data, 12-bit codes, status code 0x804 and accumulator base 0x808. With these values the index-3 code lands on 0x80B and every transfer can be compared with fixed expected codes. The bench's register model corrupts any accumulator transfer made while the status register is nonzero, so a skipped or misordered clear step shows up in the data. The model's acknowledge latency is varied from zero to three cycles. This exercises both back-to-back transfers and commands held through wait cycles, and it places requests that arrive mid-sequence at different steps.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_CLEAR, ST_ACCESS, ST_RESTORE, ST_DONE
  } step_t;

  // Control-register code for accumulator index idx.
  function automatic logic [15:0] acc_code(input logic [15:0] base, input logic [1:0] idx);
    return base + {14'd0, idx};
  endfunction
endpackage

// File: rtl/acc_guard_fsm.sv
module acc_guard_fsm
  import acc_guard_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [IW-1:0] req_idx,
  input  logic          cr_ack,
  output step_t         step,
  output logic          accept,
  output logic          op_write,
  output logic [IW-1:0] op_idx,
  output logic          busy,
  output logic          done,
  output logic          save_ack,
  output logic          access_ack,
  output logic          restore_ack,
  output logic          cr_req
);
  step_t step_q, step_d;

  assign step        = step_q;
  assign accept      = req_valid && (step_q == ST_IDLE);
  assign busy        = (step_q != ST_IDLE);
  assign done        = (step_q == ST_DONE);
  assign cr_req      = (step_q == ST_SAVE) || (step_q == ST_CLEAR) ||
                       (step_q == ST_ACCESS) || (step_q == ST_RESTORE);
  assign save_ack    = cr_ack && (step_q == ST_SAVE);
  assign access_ack  = cr_ack && (step_q == ST_ACCESS);
  assign restore_ack = cr_ack && (step_q == ST_RESTORE);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:    if (req_valid) step_d = ST_SAVE;
      ST_SAVE:    if (cr_ack)    step_d = ST_CLEAR;
      ST_CLEAR:   if (cr_ack)    step_d = ST_ACCESS;
      ST_ACCESS:  if (cr_ack)    step_d = ST_RESTORE;
      ST_RESTORE: if (cr_ack)    step_d = ST_DONE;
      ST_DONE:                   step_d = ST_IDLE;
      default:                   step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      op_write <= 1'b0;
      op_idx   <= '0;
    end else begin
      step_q <= step_d;
      if (accept) begin
        op_write <= req_write;
        op_idx   <= req_idx;
      end
    end
  end

  // R7: done follows the acknowledged restore step
  a_r7_done_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(restore_ack));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: latched operation does not move while a sequence runs
  a_r9_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(op_idx) && $stable(op_write)));
  // R1: no bus traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cr_req);
endmodule

// File: rtl/acc_guard_hold.sv
module acc_guard_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] req_wdata,
  input  logic          save_ack,
  input  logic          rd_capture,
  input  logic          busy,
  input  logic [DW-1:0] cr_rdata,
  output logic [DW-1:0] saved_stat,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved_stat <= '0;
      wdata_q    <= '0;
      rd_data    <= '0;
    end else begin
      if (accept)     wdata_q    <= req_wdata;
      if (save_ack)   saved_stat <= cr_rdata;
      if (rd_capture) rd_data    <= cr_rdata;
    end
  end

  // R8: read result stays put while no sequence is running
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rd_data));
endmodule

// File: rtl/acc_guard_seq.sv
module acc_guard_seq
  import acc_guard_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          CW        = 12,
  parameter logic [15:0] STAT_CODE = 16'h0804,
  parameter logic [15:0] ACC_BASE  = 16'h0808
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_idx,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          cr_req,
  output logic          cr_we,
  output logic [CW-1:0] cr_addr,
  output logic [DW-1:0] cr_wdata,
  input  logic          cr_ack,
  input  logic [DW-1:0] cr_rdata
);
  localparam int IW = 2;
  localparam logic [CW-1:0] STAT_A = STAT_CODE[CW-1:0];

  step_t         step;
  logic          accept, op_write, save_ack, access_ack, restore_ack;
  logic [IW-1:0] op_idx;
  logic [DW-1:0] saved_stat, wdata_q;
  logic [15:0]   acc_full;
  logic          rd_capture;

  acc_guard_fsm #(.IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .cr_ack(cr_ack), .step(step), .accept(accept),
    .op_write(op_write), .op_idx(op_idx), .busy(busy), .done(done),
    .save_ack(save_ack), .access_ack(access_ack), .restore_ack(restore_ack),
    .cr_req(cr_req)
  );

  assign rd_capture = access_ack && !op_write;

  acc_guard_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_wdata(req_wdata),
    .save_ack(save_ack), .rd_capture(rd_capture), .busy(busy),
    .cr_rdata(cr_rdata), .saved_stat(saved_stat), .wdata_q(wdata_q),
    .rd_data(rd_data)
  );

  assign acc_full = acc_code(ACC_BASE, op_idx);

  always_comb begin
    cr_we    = 1'b0;
    cr_addr  = STAT_A;
    cr_wdata = '0;
    unique case (step)
      ST_CLEAR:   cr_we = 1'b1;
      ST_ACCESS: begin
        cr_we    = op_write;
        cr_addr  = acc_full[CW-1:0];
        cr_wdata = op_write ? wdata_q : '0;
      end
      ST_RESTORE: begin
        cr_we    = 1'b1;
        cr_wdata = saved_stat;
      end
      default: ;
    endcase
  end

  // R6: a command is held until acknowledged
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && !cr_ack) |=> (cr_req && $stable(cr_we) && $stable(cr_addr) && $stable(cr_wdata)));
  // R2: the transfer after the status read is the clearing write
  a_r2_clear_follows_save: assert property (@(posedge clk) disable iff (!rst_n)
    save_ack |=> (cr_req && cr_we && cr_addr == STAT_A && cr_wdata == '0));
  // R5: restore carries the value seen at the save step
  a_r5_restore_value: assert property (@(posedge clk) disable iff (!rst_n)
    access_ack |=> (cr_req && cr_we && cr_addr == STAT_A && cr_wdata == saved_stat));
endmodule

// File: tb/tb_acc_guard_seq.sv
module tb_acc_guard_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STAT = 12'h804;
  localparam logic [11:0] BASE = 12'h808;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_idx = 0;
  logic [31:0] req_wdata = 0;
  logic        busy, done, cr_req, cr_we, cr_ack = 0;
  logic [31:0] rd_data, cr_wdata, cr_rdata = 0;
  logic [11:0] cr_addr;

  acc_guard_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr),
    .cr_wdata(cr_wdata), .cr_ack(cr_ack), .cr_rdata(cr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Register model: rounding active whenever status is nonzero corrupts data by +1.
  logic [31:0] m_stat, m_acc [4];
  int lat = 0, wcnt = 0, ack_cyc = 0, hold_err = 0;
  int log_cnt = 0;
  logic        log_we [16];
  logic [11:0] log_addr [16];
  logic [31:0] log_wd [16];
  logic        p_we;
  logic [11:0] p_addr;
  logic [31:0] p_wd;

  always @(negedge clk) begin
    cr_ack = 0;
    if (!rst_n) wcnt = 0;
    else if (cr_req) begin
      if (wcnt > 0 && (cr_we !== p_we || cr_addr !== p_addr || cr_wdata !== p_wd)) hold_err++;
      p_we = cr_we; p_addr = cr_addr; p_wd = cr_wdata;
      if (wcnt >= lat) begin
        cr_ack = 1; wcnt = 0; ack_cyc = cyc;
        if (log_cnt < 16) begin
          log_we[log_cnt] = cr_we; log_addr[log_cnt] = cr_addr; log_wd[log_cnt] = cr_wdata;
        end
        log_cnt++;
        if (cr_addr == STAT) begin
          if (cr_we) m_stat = cr_wdata; else cr_rdata = m_stat;
        end else begin
          if (cr_we) m_acc[cr_addr - BASE] = (m_stat != 0) ? cr_wdata + 1 : cr_wdata;
          else cr_rdata = (m_stat != 0) ? m_acc[cr_addr - BASE] + 1 : m_acc[cr_addr - BASE];
        end
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int done_cyc;
  // Issue one request and check the full four-step sequence.
  task automatic run_op(input bit wr, input logic [1:0] idx, input logic [31:0] d,
                        input int l, input bit poke_busy);
    logic [31:0] stat0 = m_stat;
    int guard = 0;
    lat = l; log_cnt = 0; hold_err = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_idx = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_wdata = ~d;
    chk(busy === 1'b1, "R7 busy after accept", busy, 1);
    if (poke_busy) begin
      @(negedge clk);
      req_valid = 1; req_write = ~wr; req_idx = idx + 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (done !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    done_cyc = cyc;
    chk(log_cnt == 4, "R2/R3/R9 transfer count", log_cnt, 4);
    chk(!log_we[0] && log_addr[0] == STAT, "R2 step1 status read", {log_we[0], 19'd0, log_addr[0]}, {1'b0, 19'd0, STAT});
    chk(log_we[1] && log_addr[1] == STAT && log_wd[1] == 0, "R2 step2 clear", log_wd[1], 0);
    chk(log_we[2] == wr && log_addr[2] == BASE + idx, "R4 step3 accumulator code", log_addr[2], BASE + idx);
    if (wr) chk(log_wd[2] == d, "R3 step3 write data", log_wd[2], d);
    chk(log_we[3] && log_addr[3] == STAT && log_wd[3] == stat0, "R5 restore value", log_wd[3], stat0);
    chk(m_stat == stat0, "R5 status restored", m_stat, stat0);
    chk(done_cyc == ack_cyc + 1, "R7 done timing", done_cyc, ack_cyc + 1);
    chk(hold_err == 0, "R6 command held through wait", hold_err, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 done single pulse, busy low", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(log_cnt == 4, "R9 no extra transfer", log_cnt, 4);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && cr_req === 0, "R1 reset outputs", {busy, done, cr_req}, 0);
    chk(rd_data === 0, "R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_read3;
    m_stat = 32'h30; m_acc[3] = 32'hA5A5_0003;
    run_op(0, 3, 0, 0, 0);
    chk(log_addr[2] == 12'h80B, "R4 index 3 code", log_addr[2], 12'h80B);
    chk(rd_data == 32'hA5A5_0003, "R8 raw read idx3", rd_data, 32'hA5A5_0003);
  endtask

  task automatic t_read0_slow;
    m_stat = 32'h1; m_acc[0] = 32'h1234_5678;
    run_op(0, 0, 0, 3, 0);
    chk(rd_data == 32'h1234_5678, "R8 raw read idx0 slow ack", rd_data, 32'h1234_5678);
  endtask

  task automatic t_write_then_read;
    logic [31:0] prev = rd_data;
    m_stat = 32'h20;
    run_op(1, 2, 32'hDEAD_BEEF, 1, 0);
    chk(m_acc[2] == 32'hDEAD_BEEF, "R3 exact bits written idx2", m_acc[2], 32'hDEAD_BEEF);
    chk(rd_data == prev, "R8 write leaves rd_data", rd_data, prev);
    run_op(0, 2, 0, 2, 0);
    chk(rd_data == 32'hDEAD_BEEF, "R8 read back idx2", rd_data, 32'hDEAD_BEEF);
  endtask

  task automatic t_busy_ignore;
    m_stat = 32'h7; m_acc[1] = 32'h0BAD_F00D; m_acc[2] = 32'h5555_5555;
    run_op(0, 1, 0, 2, 1);
    chk(rd_data == 32'h0BAD_F00D, "R9 ignored request kept idx1 read", rd_data, 32'h0BAD_F00D);
    chk(m_acc[2] == 32'h5555_5555, "R9 ignored write had no effect", m_acc[2], 32'h5555_5555);
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_read3();
    t_read0_slow();
    t_write_then_read();
    t_busy_ignore();
    run_op(1, 0, 32'h0000_FFFF, 0, 1);
    chk(m_acc[0] == 32'h0000_FFFF, "R3 write idx0 while poked", m_acc[0], 32'h0000_FFFF);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule